// File: doc/BRIEF.md
# Daisy-Chain Bus Grant Chain

This block arbitrates a shared bus among several masters that sit one after another on a chain. Each master raises its own request, and the block combines them into one shared request line. When the bus is free and that line is high, the central arbiter starts a single grant token at the first stage. The token moves one stage per clock. A stage that is not requesting passes the token on to the next stage. A stage that is requesting keeps the token, takes ownership and raises the shared busy line.

The position of a stage on the chain is its priority: the stage nearest the arbiter wins. Only three shared lines are involved, whatever the chain length: request, grant and busy. The owner lowers busy by pulsing the transfer-done input. A token that reaches the end of the chain unclaimed is dropped, and a new round starts if requests remain.

Top module: `daisy_grant_chain`

## Requirements
- R1: `bus_req` is high exactly when at least one bit of `req_i` is high, in the same cycle.
- R2: After reset, `bus_grant`, `grant_out`, `bus_busy` and `owner_vld` are all 0.
- R3: The arbiter starts a round when, at a clock edge, `bus_req` is high, `bus_busy` is low and no token is on the chain. `bus_grant` (the token at stage 0) is then high for the following cycle. No token is started while busy or while a token is in flight.
- R4: The token is at stage k exactly k cycles after `bus_grant` was high. While stage k holds it with `req_i[k]`=0, `grant_out[k]` is 1. Otherwise `grant_out[k]` is 0.
- R5: A stage that holds the token with its request high captures it at the next edge. From the following cycle `bus_busy`=1, `owner_vld`=1 and `owner_id`=k, so ownership appears k+1 cycles after `bus_grant`.
- R6: With requests held steady during a round, the lowest-index requesting stage becomes owner.
- R7: Busy and ownership hold, with `owner_id` unchanged, until an edge at which `xfer_done`=1. The next cycle `bus_busy`=0. `xfer_done` has no effect while not busy.
- R8: A request raised at a stage the token has already passed is not served in that round. If no stage claims the token, it is dropped after stage N-1, and the request is served in a later round.
- R9: At most one bit of `grant_out` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_MASTERS | Per-stage bus request |
| xfer_done | input | 1 | Owner signals end of its transfer |
| bus_req | output | 1 | Shared OR of all requests |
| bus_grant | output | 1 | Arbiter grant into stage 0 |
| bus_busy | output | 1 | Bus occupied by an owner |
| grant_out | output | N_MASTERS | Grant passed on by each stage |
| owner_vld | output | 1 | `owner_id` is valid |
| owner_id | output | IW | Index of the current owner, 0 when none |

## Verification
The assertions assume that requests and `xfer_done` change only between clock edges. They also assume that `xfer_done` matters only while an owner holds the bus; a pulse at any other time must leave the state untouched. The stimulus drives every input at the falling edge. It pulses `xfer_done` at random, including while the bus is idle, so the claim that it is ignored is exercised. Requests toggle at random while tokens are moving, which exposes stages the token has already passed.

// File: rtl/daisy_grant_chain.sv
module daisy_grant_chain #(
  parameter int N_MASTERS = 4,
  parameter int IW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MASTERS-1:0] req_i,
  input  logic                 xfer_done,
  output logic                 bus_req,
  output logic                 bus_grant,
  output logic                 bus_busy,
  output logic [N_MASTERS-1:0] grant_out,
  output logic                 owner_vld,
  output logic [IW-1:0]        owner_id
);
  localparam logic [IW-1:0] LAST = IW'(N_MASTERS - 1);

  logic          tok_v;
  logic [IW-1:0] tok_pos;
  logic          busy_q;
  logic [IW-1:0] owner_q;
  logic [N_MASTERS-1:0] grant_in;

  assign bus_req = |req_i;

  for (genvar k = 0; k < N_MASTERS; k++) begin : g_stage
    assign grant_in[k]  = tok_v && (tok_pos == IW'(k));
    assign grant_out[k] = grant_in[k] & ~req_i[k];
  end

  assign bus_grant = grant_in[0];
  assign bus_busy  = busy_q;
  assign owner_vld = busy_q;
  assign owner_id  = busy_q ? owner_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tok_v   <= 1'b0;
      tok_pos <= '0;
      busy_q  <= 1'b0;
      owner_q <= '0;
    end else if (busy_q) begin
      if (xfer_done) busy_q <= 1'b0;
    end else if (tok_v) begin
      if (req_i[tok_pos]) begin
        busy_q  <= 1'b1;
        owner_q <= tok_pos;
        tok_v   <= 1'b0;
      end else if (tok_pos == LAST) begin
        tok_v <= 1'b0;
      end else begin
        tok_pos <= tok_pos + 1'b1;
      end
    end else if (bus_req) begin
      tok_v   <= 1'b1;
      tok_pos <= '0;
    end
  end

  a_r9_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_out));

  a_r7_no_grant_busy: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy |-> (!bus_grant && grant_out == '0));

  a_r7_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && !xfer_done) |=> (bus_busy && $stable(owner_id)));

  a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_v && req_i[tok_pos]) |=> (bus_busy && owner_id == $past(tok_pos)));

  a_r4_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_v && !req_i[tok_pos] && tok_pos != LAST) |=>
      (tok_v && tok_pos == $past(tok_pos) + 1'b1));

  a_r3_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (!tok_v && !bus_busy && bus_req) |=> bus_grant);
endmodule

// File: tb/daisy_grant_chain_bench.sv
`timescale 1ns/1ps
module daisy_grant_chain_bench;
  localparam int N = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req_i = '0;
  logic xfer_done = 1'b0;
  logic bus_req, bus_grant, bus_busy, owner_vld;
  logic [N-1:0] grant_out;
  logic [IW-1:0] owner_id;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int g_at = -1;
  int b_at = -1;
  bit finished = 0;

  bit m_tok;
  int m_pos;
  bit m_busy;
  int m_owner;

  always #2 clk = ~clk;

  daisy_grant_chain #(.N_MASTERS(N)) u_daisy_grant_chain (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .xfer_done(xfer_done),
    .bus_req(bus_req), .bus_grant(bus_grant), .bus_busy(bus_busy),
    .grant_out(grant_out), .owner_vld(owner_vld), .owner_id(owner_id));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic int exp_gout(logic [N-1:0] r);
    int v = 0;
    if (m_tok && !r[m_pos]) v = 1 << m_pos;
    return v;
  endfunction

  task automatic model_reset();
    m_tok = 0; m_pos = 0; m_busy = 0; m_owner = 0;
  endtask

  task automatic model_step(logic [N-1:0] r, logic d);
    if (m_busy) begin
      if (d) m_busy = 0;
    end else if (m_tok) begin
      if (r[m_pos]) begin m_busy = 1; m_owner = m_pos; m_tok = 0; end
      else if (m_pos == N-1) m_tok = 0;
      else m_pos++;
    end else if (r != 0) begin
      m_tok = 1; m_pos = 0;
    end
  endtask

  task automatic step(logic [N-1:0] r, logic d);
    @(negedge clk);
    req_i = r;
    xfer_done = d;
    #1;
    chk("R1 bus_req", bus_req, (r != 0));
    chk("R3 bus_grant", bus_grant, (m_tok && m_pos == 0));
    chk("R4 grant_out", grant_out, exp_gout(r));
    chk("R7 bus_busy", bus_busy, m_busy);
    chk("R5 owner_vld", owner_vld, m_busy);
    chk("R5 owner_id", owner_id, m_busy ? m_owner : 0);
    chk("R9 grant onehot", ($countones(grant_out) <= 1), 1);
    if (bus_grant && g_at < 0) g_at = cyc;
    if (owner_vld && b_at < 0) b_at = cyc;
    @(posedge clk);
    model_step(r, d);
    cyc++;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R2 reset bus_grant", bus_grant, 0);
    chk("R2 reset grant_out", grant_out, 0);
    chk("R2 reset busy", bus_busy, 0);
    chk("R2 reset owner_vld", owner_vld, 0);

    // R7: done while idle has no effect
    step(4'b0000, 1'b1);
    step(4'b0000, 1'b0);
    chk("R7 idle done ignored", bus_busy, 0);

    // R4/R5 latency: only stage 3 requests
    g_at = -1; b_at = -1;
    for (int i = 0; i < 8; i++) step(4'b1000, 1'b0);
    chk("R5 owner latency stage3", b_at - g_at, 4);
    chk("R5 owner stage3", owner_id, 3);
    step(4'b1000, 1'b0);
    step(4'b1000, 1'b0);
    chk("R7 busy held", bus_busy, 1);
    step(4'b0000, 1'b1);
    step(4'b0000, 1'b0);
    chk("R7 released", bus_busy, 0);

    // latency for stage 1
    g_at = -1; b_at = -1;
    for (int i = 0; i < 5; i++) step(4'b0010, 1'b0);
    chk("R5 owner latency stage1", b_at - g_at, 2);
    step(4'b0000, 1'b1);
    step(4'b0000, 1'b0);

    // R6 priority
    for (int i = 0; i < 6; i++) step(4'b1010, 1'b0);
    chk("R6 priority lowest index", owner_id, 1);
    step(4'b1000, 1'b1);
    for (int i = 0; i < 6; i++) step(4'b1000, 1'b0);
    chk("R6 next owner", owner_id, 3);
    step(4'b0000, 1'b1);
    step(4'b0000, 1'b0);

    // R8 late request behind the token
    step(4'b0100, 1'b0);
    step(4'b0100, 1'b0);
    step(4'b0001, 1'b0);
    step(4'b0001, 1'b0);
    step(4'b0001, 1'b0);
    chk("R8 no owner in first round", owner_vld, 0);
    step(4'b0001, 1'b0);
    step(4'b0001, 1'b0);
    step(4'b0001, 1'b0);
    chk("R8 served next round", owner_vld, 1);
    chk("R8 owner stage0", owner_id, 0);
    step(4'b0000, 1'b1);

    // random phase
    begin
      logic [N-1:0] r = '0;
      for (int i = 0; i < 3000; i++) begin
        for (int b = 0; b < N; b++)
          if ($urandom % 6 == 0) r[b] = ~r[b];
        step(r, ($urandom % 5 == 0));
      end
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule